// File: doc/BRIEF.md
# Multiply-Accumulate Register Peripheral

This block is a multiplier that sits on a simple synchronous register bus with 16-bit data and a two-lane byte enable. Software picks the operation through the address it uses to write the first operand. There are four choices: unsigned product, signed product, unsigned accumulate and signed accumulate. A write to the second operand starts the operation. The 32-bit answer lands in a low and a high result word in the same clock edge, and a third word holds the extension of the sum.

Operands may be full words or single bytes, so all four size pairings (word by word, word by byte, byte by word, byte by byte) come from one datapath. A byte operand is widened as it is stored: with zeros for unsigned operations and with its sign bit for signed ones.

The first operand and the chosen operation stay stored. A series of second-operand writes therefore reuses them, which makes running dot products cheap. Software can preload the accumulator by writing the two result words. Every access is accepted in the cycle it is presented. There is no back-pressure and no wait state, and read data is valid combinationally in the cycle of the read.

Top module: `mac_unit`

## Requirements
- R1: After reset, every register reads 0x0000 and the stored operation is unsigned multiply.
- R2: A write to word offset 0x0, 0x2, 0x4 or 0x6 from the base stores operand A and selects, respectively, unsigned multiply, signed multiply, unsigned accumulate or signed accumulate. Operand A reads back at any of those four offsets.
- R3: A write to offset 0x8 stores operand B and computes the result in that same edge. The result reads at offset 0xA (low word) and 0xC (high word) in the very next cycle.
- R4: Unsigned multiply gives A*B as unsigned values. The extension word (offset 0xE) becomes 0x0000.
- R5: Signed multiply gives the two's-complement product. The extension word becomes 0xFFFF if the product is negative and 0x0000 otherwise.
- R6: Unsigned accumulate adds the unsigned product to the 32-bit result, modulo 2^32. The extension word becomes 0x0001 on a carry out and 0x0000 otherwise.
- R7: Signed accumulate adds the signed product to the 32-bit result. The extension word becomes 0xFFFF if bit 31 of the new result is set and 0x0000 otherwise.
- R8: Byte-enable 2'b01 writes a byte taken from data bits 7:0, and 2'b10 writes a byte taken from bits 15:8. A byte operand is zero-extended in unsigned operations and sign-extended in signed ones. Byte-enable 2'b00 has no effect.
- R9: Operand A and the operation stay until operand A is written again, so repeated writes to operand B reuse them.
- R10: The low and high result words can be written, per byte lane, to preset the accumulator. The extension word is read-only and changes only when operand B is written.
- R11: Reads have no side effects. Odd addresses and addresses outside the 16-byte window read 0x0000, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request, taken in the cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (16) | Byte address |
| bus_be | input | 2 | Byte-lane enables for a write (bit 0 = bits 7:0) |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data, valid in the same cycle as a read request |

## Verification
On every cycle, the embedded properties check the following. The extension word takes only the values its operation allows. Operand A, the operation and the result hold steady whenever no write targets them. An unsigned byte write to operand A leaves its upper byte clear. Only the bench scenarios can show that the arithmetic itself is right: exact products at the sign and carry boundaries, accumulation across preset values, and repeated operand-B writes. The same applies to the zero-wait read after the operand-B write and to the lack of effect of unmapped or disabled writes.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // bit 0 = signed, bit 1 = accumulate; taken from address bits 2:1
  typedef enum logic [1:0] {
    MODE_UMPY = 2'b00,
    MODE_SMPY = 2'b01,
    MODE_UMAC = 2'b10,
    MODE_SMAC = 2'b11
  } mac_mode_e;

  // word index inside the 16-byte window (address bits 3:1)
  localparam logic [2:0] IDX_OPB   = 3'd4;
  localparam logic [2:0] IDX_RESLO = 3'd5;
  localparam logic [2:0] IDX_RESHI = 3'd6;
  localparam logic [2:0] IDX_EXT   = 3'd7;
endpackage

// File: rtl/mac_operand_ext.sv
module mac_operand_ext #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    be,
  input  logic          is_signed,
  output logic [DW-1:0] value
);
  localparam int HB = DW / 2;

  always_comb begin
    unique case (be)
      2'b01:   value = {{HB{is_signed & wdata[HB-1]}}, wdata[HB-1:0]};
      2'b10:   value = {{HB{is_signed & wdata[DW-1]}}, wdata[DW-1:HB]};
      default: value = wdata;
    endcase
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DW = 16
) (
  input  mac_mode_e       mode,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [2*DW-1:0] acc,
  output logic [2*DW-1:0] res,
  output logic [DW-1:0]   ext
);
  localparam int RW = 2 * DW;

  logic          sgn;
  logic [RW-1:0] a_w, b_w, prod;
  logic [RW:0]   sum;

  assign sgn  = mode[0];
  assign a_w  = {{DW{sgn & opa[DW-1]}}, opa};
  assign b_w  = {{DW{sgn & opb[DW-1]}}, opb};
  assign prod = a_w * b_w;
  assign sum  = {1'b0, acc} + {1'b0, prod};

  always_comb begin
    unique case (mode)
      MODE_UMPY: begin res = prod;       ext = '0; end
      MODE_SMPY: begin res = prod;       ext = {DW{prod[RW-1]}}; end
      MODE_UMAC: begin res = sum[RW-1:0]; ext = {{(DW-1){1'b0}}, sum[RW]}; end
      default:   begin res = sum[RW-1:0]; ext = {DW{sum[RW-1]}}; end
    endcase
  end
endmodule

// File: rtl/mac_result_regs.sv
module mac_result_regs #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_calc,
  input  logic [2*DW-1:0] calc_res,
  input  logic [DW-1:0]   calc_ext,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [1:0]      be,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] res_q,
  output logic [DW-1:0]   ext_q
);
  localparam int HB = DW / 2;

  logic [DW-1:0] merged;

  always_comb begin
    merged = wr_hi ? res_q[2*DW-1:DW] : res_q[DW-1:0];
    if (be[0]) merged[HB-1:0]  = wdata[HB-1:0];
    if (be[1]) merged[DW-1:HB] = wdata[DW-1:HB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ext_q <= '0;
    end else if (load_calc) begin
      res_q <= calc_res;
      ext_q <= calc_ext;
    end else if (wr_lo) begin
      res_q[DW-1:0] <= merged;
    end else if (wr_hi) begin
      res_q[2*DW-1:DW] <= merged;
    end
  end

  // R10
  ext_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_calc |=> $stable(ext_q));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int              DW   = 16,
  parameter int              AW   = 16,
  parameter logic [AW-1:0]   BASE = 16'h0130
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int HB = DW / 2;
  localparam int RW = 2 * DW;

  logic          hit, wr_any, rd_any;
  logic [2:0]    idx;
  logic          opa_wr, opb_wr, lo_wr, hi_wr;
  mac_mode_e     mode_q;
  logic [DW-1:0] opa_q, opb_q, opa_new, opb_new;
  logic [RW-1:0] res_q, calc_res;
  logic [DW-1:0] ext_q, calc_ext;

  assign hit    = (bus_addr[AW-1:4] == BASE[AW-1:4]) && !bus_addr[0];
  assign idx    = bus_addr[3:1];
  assign wr_any = bus_sel && bus_we && hit && (|bus_be);
  assign rd_any = bus_sel && !bus_we && hit;
  assign opa_wr = wr_any && !idx[2];
  assign opb_wr = wr_any && (idx == IDX_OPB);
  assign lo_wr  = wr_any && (idx == IDX_RESLO);
  assign hi_wr  = wr_any && (idx == IDX_RESHI);

  mac_operand_ext #(.DW(DW)) u_exta (
    .wdata(bus_wdata), .be(bus_be), .is_signed(bus_addr[1]), .value(opa_new));

  mac_operand_ext #(.DW(DW)) u_extb (
    .wdata(bus_wdata), .be(bus_be), .is_signed(mode_q[0]), .value(opb_new));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      mode_q <= MODE_UMPY;
    end else begin
      if (opa_wr) begin
        opa_q  <= opa_new;
        mode_q <= mac_mode_e'(bus_addr[2:1]);
      end
      if (opb_wr) opb_q <= opb_new;
    end
  end

  mac_datapath #(.DW(DW)) u_dp (
    .mode(mode_q), .opa(opa_q), .opb(opb_new), .acc(res_q),
    .res(calc_res), .ext(calc_ext));

  mac_result_regs #(.DW(DW)) u_res (
    .clk(clk), .rst_n(rst_n), .load_calc(opb_wr), .calc_res(calc_res),
    .calc_ext(calc_ext), .wr_lo(lo_wr), .wr_hi(hi_wr), .be(bus_be),
    .wdata(bus_wdata), .res_q(res_q), .ext_q(ext_q));

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      unique case (idx)
        IDX_OPB:   bus_rdata = opb_q;
        IDX_RESLO: bus_rdata = res_q[DW-1:0];
        IDX_RESHI: bus_rdata = res_q[RW-1:DW];
        IDX_EXT:   bus_rdata = ext_q;
        default:   bus_rdata = opa_q;
      endcase
    end
  end

  // R4
  umpy_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opb_wr && mode_q == MODE_UMPY) |=> (ext_q == '0));
  // R5
  smpy_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opb_wr && mode_q == MODE_SMPY) |=> (ext_q == '0 || ext_q == '1));
  // R6
  umac_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opb_wr && mode_q == MODE_UMAC) |=> (ext_q[DW-1:1] == '0));
  // R7
  smac_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opb_wr && mode_q == MODE_SMAC) |=> (ext_q == {DW{res_q[RW-1]}}));
  // R9
  opa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !opa_wr |=> ($stable(opa_q) && $stable(mode_q)));
  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(opb_wr || lo_wr || hi_wr) |=> $stable(res_q));
  // R8
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opa_wr && bus_be != 2'b11 && !bus_addr[1]) |=> (opa_q[DW-1:HB] == '0));
endmodule

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;
  localparam logic [15:0] BASE = 16'h0130;
  localparam logic [15:0] A_OPB = BASE + 16'h8;
  localparam logic [15:0] A_LO  = BASE + 16'hA;
  localparam logic [15:0] A_HI  = BASE + 16'hC;
  localparam logic [15:0] A_EXT = BASE + 16'hE;

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] a;
    logic [15:0] b;
    logic [31:0] pre;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [15:0] ext;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'h1234, 16'h0010, 32'h0,         16'h2340, 16'h0001, 16'h0000},
    '{2'd0, 16'hFFFF, 16'hFFFF, 32'h0,         16'h0001, 16'hFFFE, 16'h0000},
    '{2'd1, 16'hFFFF, 16'hFFFF, 32'h0,         16'h0001, 16'h0000, 16'h0000},
    '{2'd1, 16'hFFFE, 16'h0003, 32'h0,         16'hFFFA, 16'hFFFF, 16'hFFFF},
    '{2'd2, 16'h0001, 16'h0001, 32'hFFFFFFFF,  16'h0000, 16'h0000, 16'h0001},
    '{2'd2, 16'h0002, 16'h0003, 32'h00000010,  16'h0016, 16'h0000, 16'h0000},
    '{2'd3, 16'hFFFF, 16'h0008, 32'h00000005,  16'hFFFD, 16'hFFFF, 16'hFFFF},
    '{2'd3, 16'h0004, 16'h0005, 32'hFFFFFFF0,  16'h0004, 16'h0000, 16'h0000},
    '{2'd1, 16'h8000, 16'h8000, 32'h0,         16'h0000, 16'h4000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  task automatic wr(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] got;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 got = bus_rdata;
    bus_sel = 1'b0;
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, got, exp);
    end
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1 opa", BASE, 16'h0);
    chk("R1 opb", A_OPB, 16'h0);
    chk("R1 lo", A_LO, 16'h0);
    chk("R1 hi", A_HI, 16'h0);
    chk("R1 ext", A_EXT, 16'h0);
    // R1: default operation is unsigned multiply
    wr(A_OPB, 2'b11, 16'h0005);
    chk("R1 mode", A_LO, 16'h0000);

    // R2 R3 R4 R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      wr(A_LO, 2'b11, VEC[i].pre[15:0]);
      wr(A_HI, 2'b11, VEC[i].pre[31:16]);
      wr(BASE + {13'd0, VEC[i].mode, 1'b0}, 2'b11, VEC[i].a);
      wr(A_OPB, 2'b11, VEC[i].b);
      chk($sformatf("R3 vec%0d lo", i), A_LO, VEC[i].lo);
      chk($sformatf("R4-7 vec%0d hi", i), A_HI, VEC[i].hi);
      chk($sformatf("R4-7 vec%0d ext", i), A_EXT, VEC[i].ext);
      chk($sformatf("R2 vec%0d opa", i), BASE + 16'h6, VEC[i].a);
    end

    // R8 byte operands
    wr(BASE + 16'h2, 2'b01, 16'h3480);
    chk("R8 signed low lane", BASE, 16'hFF80);
    wr(BASE + 16'h0, 2'b01, 16'h3480);
    chk("R8 unsigned low lane", BASE, 16'h0080);
    wr(BASE + 16'h2, 2'b10, 16'h8177);
    chk("R8 signed high lane", BASE, 16'hFF81);
    wr(BASE + 16'h0, 2'b00, 16'h1111);
    chk("R8 be00 ignored", BASE, 16'hFF81);
    wr(BASE + 16'h2, 2'b11, 16'h0002);
    wr(A_OPB, 2'b01, 16'h00FF);
    chk("R8 opb sext lo", A_LO, 16'hFFFE);
    chk("R8 opb sext ext", A_EXT, 16'hFFFF);

    // R9 reuse operand A and operation
    wr(A_OPB, 2'b11, 16'h0003);
    chk("R9 reuse lo", A_LO, 16'h0006);
    chk("R9 reuse ext", A_EXT, 16'h0000);
    wr(A_LO, 2'b11, 16'h0000);
    wr(A_HI, 2'b11, 16'h0000);
    wr(BASE + 16'h4, 2'b11, 16'h0010);
    wr(A_OPB, 2'b11, 16'h0001);
    wr(A_OPB, 2'b11, 16'h0001);
    chk("R9 double accumulate", A_LO, 16'h0020);

    // R10 lane preset and read-only extension
    wr(A_HI, 2'b10, 16'hAB00);
    chk("R10 hi lane", A_HI, 16'hAB00);
    wr(A_EXT, 2'b11, 16'h1234);
    chk("R10 ext ro", A_EXT, 16'h0000);

    // R11 unmapped and odd accesses
    chk("R11 unmapped read", BASE + 16'h10, 16'h0000);
    wr(BASE + 16'h10, 2'b11, 16'h5555);
    wr(A_LO + 16'h1, 2'b11, 16'h7777);
    chk("R11 lo untouched", A_LO, 16'h0020);
    chk("R11 hi untouched", A_HI, 16'hAB00);
    chk("R11 repeated read", A_LO, 16'h0020);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule